// File: doc/BRIEF.md
# Manchester Line Decoder with Activity Flag

This block turns a Manchester-coded serial line back into plain bits. An external tick, running at twice the bit rate and lined up with the half-bit boundaries, tells the block when to look at the line. Ticks alternate between the first half and the second half of each bit. The block stores the first-half level. On the second-half tick it compares the two halves and registers a result.

A falling edge in the middle of the bit gives a decoded 1. A rising edge in the middle of the bit gives a decoded 0. When both halves carry the same level, the line is inactive and no bit was sent. The activity flag lets a consumer tell a real decoded 0 apart from a quiet line: a 0 counts only when the flag is high. Recovering the clock, searching for bit boundaries and framing are handled outside this block.

Top module: `manch_decoder`

## Requirements
- R1: A synchronous active-high reset drives `data_out` and `valid_out` to 0 and returns the half-bit phase to "first half". The first tick after reset is therefore treated as a first-half sample.
- R2: `data_out` and `valid_out` change only on a clock edge where `smp_tick` is high and the phase is "second half". On every other edge they hold their value.
- R3: Rising mid-bit transition: first half 0, second half 1. This registers `data_out`=0 and `valid_out`=1.
- R4: Falling mid-bit transition: first half 1, second half 0. This registers `data_out`=1 and `valid_out`=1.
- R5: Equal halves (0/0 or 1/1) register `valid_out`=0 and `data_out`=0. As a result, `data_out`=1 never appears without `valid_out`=1.
- R6: The phase toggles only on edges where `smp_tick` is high. Clock edges without a tick do not advance it, and a first-half tick leaves the outputs unchanged.
- R7: The result of a bit is visible right after the clock edge that takes the second-half sample, which is one register stage. Back-to-back ticks on consecutive cycles are decoded correctly.
- R8: `line_in` is sampled only on tick edges. Line changes between ticks have no effect on the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Manchester-coded serial line |
| smp_tick | input | 1 | Half-bit sample enable, one cycle wide |
| data_out | output | 1 | Decoded bit, registered |
| valid_out | output | 1 | High when the last bit had a mid-bit transition |

## Verification
Each decoded result is due exactly one clock edge after the second-half tick. A first-half tick, or a cycle with no tick, must leave both outputs as they were. The bench models the phase and both outputs behaviourally, advancing the model on every rising edge. It compares the model against the design at every falling edge, which is half a period after the edge that updated the registers. Stimulus changes only at falling edges, including the glitches placed between ticks.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  // Registered decoder result
  typedef struct packed {
    logic data;
    logic valid;
  } mdec_res_t;

  // Decode rule: falling mid-bit edge -> 1, rising -> 0, no edge -> inactive
  function automatic mdec_res_t mdec_judge_bit(input logic first_h, input logic second_h);
    mdec_res_t r;
    r.valid = first_h ^ second_h;
    r.data  = first_h & ~second_h;
    return r;
  endfunction
endpackage

// File: rtl/mdec_phase.sv
module mdec_phase #(
  parameter int SAMPLES_PER_BIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic at_first,
  output logic at_last
);
  localparam int PH_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;
  localparam logic [PH_W-1:0] LAST_IDX = PH_W'(SAMPLES_PER_BIT - 1);

  logic [PH_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (tick) begin
      if (idx_q == LAST_IDX) idx_q <= '0;
      else                   idx_q <= idx_q + 1'b1;
    end
  end

  assign at_first = (idx_q == '0);
  assign at_last  = (idx_q == LAST_IDX);
endmodule

// File: rtl/mdec_sampler.sv
module mdec_sampler (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic line,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst)       held <= 1'b0;
    else if (take) held <= line;
  end
endmodule

// File: rtl/mdec_outreg.sv
module mdec_outreg
  import mdec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic first_h,
  input  logic second_h,
  output logic data_q,
  output logic valid_q
);
  mdec_res_t res_q;
  mdec_res_t res_d;

  always_comb res_d = mdec_judge_bit(first_h, second_h);

  always_ff @(posedge clk) begin
    if (rst)         res_q <= '0;
    else if (commit) res_q <= res_d;
  end

  assign data_q  = res_q.data;
  assign valid_q = res_q.valid;
endmodule

// File: rtl/manch_decoder.sv
module manch_decoder #(
  parameter int SAMPLES_PER_BIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic smp_tick,
  output logic data_out,
  output logic valid_out
);
  logic ph_first, ph_last;
  logic first_sample;

  mdec_phase #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT)) u_phase (
    .clk(clk), .rst(rst), .tick(smp_tick),
    .at_first(ph_first), .at_last(ph_last)
  );

  mdec_sampler u_first (
    .clk(clk), .rst(rst), .take(smp_tick & ph_first),
    .line(line_in), .held(first_sample)
  );

  mdec_outreg u_out (
    .clk(clk), .rst(rst), .commit(smp_tick & ph_last),
    .first_h(first_sample), .second_h(line_in),
    .data_q(data_out), .valid_q(valid_out)
  );
endmodule

// File: rtl/manch_decoder_chk.sv
module manch_decoder_chk (
  input logic clk,
  input logic rst,
  input logic line_in,
  input logic smp_tick,
  input logic data_out,
  input logic valid_out
);
  // Independent half tracker built from port activity only
  logic second_now;
  logic first_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      second_now <= 1'b0;
      first_seen <= 1'b0;
    end else if (smp_tick) begin
      second_now <= ~second_now;
      if (!second_now) first_seen <= line_in;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!data_out && !valid_out));

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !smp_tick |=> ($stable(data_out) && $stable(valid_out)));

  a_r6_first_half_hold: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && !second_now) |=> ($stable(data_out) && $stable(valid_out)));

  a_r3_rising_is_zero: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && second_now && !first_seen && line_in) |=> (!data_out && valid_out));

  a_r4_falling_is_one: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && second_now && first_seen && !line_in) |=> (data_out && valid_out));

  a_r5_equal_inactive: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && second_now && (first_seen == line_in)) |=> (!data_out && !valid_out));

  a_r5_one_needs_valid: assert property (@(posedge clk) disable iff (rst)
    data_out |-> valid_out);
endmodule

bind manch_decoder manch_decoder_chk u_chk (
  .clk(clk), .rst(rst), .line_in(line_in), .smp_tick(smp_tick),
  .data_out(data_out), .valid_out(valid_out)
);

// File: tb/manch_decoder_tb.sv
module manch_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic smp_tick = 1'b0;
  logic data_out, valid_out;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference state
  int  m_half = 0;
  bit  m_first = 0;
  bit  m_data = 0;
  bit  m_valid = 0;

  always #10 clk = ~clk;

  manch_decoder u_dut (
    .clk(clk), .rst(rst), .line_in(line_in), .smp_tick(smp_tick),
    .data_out(data_out), .valid_out(valid_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_half = 0; m_first = 0; m_data = 0; m_valid = 0;
    end else if (smp_tick) begin
      if (m_half == 0) begin
        m_first = line_in;
        m_half = 1;
      end else begin
        m_valid = (m_first != line_in);
        m_data  = (m_first == 1) && (line_in == 0);
        m_half = 0;
      end
    end
  end

  task automatic compare();
    vectors++;
    if (data_out !== m_data || valid_out !== m_valid) begin
      miscompares++;
      $display("FAIL %s: data/valid actual %b/%b expected %b/%b at cycle %0d",
               tag, data_out, valid_out, m_data, m_valid, cycles);
    end
  endtask

  // one clock: check at falling edge, then apply next inputs
  task automatic step(input bit ln, input bit tk);
    @(negedge clk);
    compare();
    line_in = ln;
    smp_tick = tk;
  endtask

  // one half-bit sample followed by gap cycles; glitch toggles line between ticks (R8)
  task automatic half(input bit lvl, input int gap, input bit glitch);
    step(lvl, 1'b1);
    for (int g = 0; g < gap; g++) step(glitch ? ~lvl : lvl, 1'b0);
  endtask

  task automatic send(input bit b, input int gap, input bit glitch);
    half(b, gap, glitch);        // falling for 1, rising for 0
    half(~b, gap, glitch);
  endtask

  task automatic settle();
    step(line_in, 1'b0);
    step(line_in, 1'b0);
  endtask

  initial begin
    tag = "R1";
    step(0, 0); step(0, 0);
    rst = 1'b0;
    step(0, 0);                              // reset values
    tag = "R4"; send(1, 1, 0); settle();
    tag = "R3"; send(0, 1, 0); settle();
    tag = "R5"; half(0, 1, 0); half(0, 1, 0); settle();
    tag = "R5"; half(1, 1, 0); half(1, 1, 0); settle();
    tag = "R2"; send(1, 3, 0); settle();
    tag = "R6"; half(1, 4, 0); settle(); half(0, 4, 0); settle();
    tag = "R7"; send(1, 0, 0); send(0, 0, 0); send(1, 0, 0); send(1, 0, 0); settle();
    tag = "R8"; send(0, 3, 1); send(1, 3, 1); half(1, 2, 1); half(1, 2, 1); settle();
    tag = "R7";
    for (int i = 0; i < 40; i++) send(((i * 7) % 5) > 1, i % 3, i[0]);
    settle();
    tag = "R1";
    half(1, 0, 0);                           // first half only, then reset
    @(negedge clk); compare(); rst = 1'b1; smp_tick = 1'b0;
    step(0, 0);
    rst = 1'b0;
    step(0, 0);
    tag = "R1"; send(1, 1, 0); settle();     // decoded as a fresh bit
    tag = "R3"; send(0, 2, 0); settle();
    report();
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule